// File: doc/BRIEF.md
# Dual-Channel Wiper Register SPI Front End

This block is the serial control front end of a two-channel register device, such as the controller of a digital potentiometer. A master selects it with an active-low chip select and clocks in frames MSB first. Each frame starts with an address byte: a fixed device identity and two bits that must equal the strap pins. A command byte follows, and for reads and writes a data byte after it. Each channel holds an 8-bit wiper register. The register is decoded into a registered one-hot tap select of 256 lines. Each channel also has a shadow value that stands in for nonvolatile storage. A store to the shadow shows outward as a single-cycle commit strobe.

All serial inputs are brought into the system clock domain through two-stage synchronizers. Edges of the serial clock are found by comparing the synchronized level with its previous value. The master may pause a frame with the hold input and resume it later without losing any bits. After reset the block ignores the bus until it has seen chip select fall. A low write-protect input blocks stores to the shadow but still allows volatile wiper writes.

Top module: `potctl_spi_wiper`

## Requirements
- R1: After reset both wipers equal their shadow values, which start at 0x80. Each tap select then has only bit 128 set, sdo_oe is low, and no commit strobe occurs.
- R2: While chip select is high, sdo_oe is low and the frame state returns to the address byte. While the block is selected and unlocked, sdo_oe is high.
- R3: After reset, every bus activity is ignored until the first high-to-low transition of cs_n. A frame sent with cs_n low since reset changes nothing, and the first properly selected frame after that transition is accepted.
- R4: sdi is sampled on rising sck edges, MSB first. Byte 0 carries the identity 4'b0101 in bits 7:4, the strap value in bits 3:2, and don't-care bits in 1:0. Byte 1 carries the opcode in bits 7:6 (00 read, 01 write, 10 store, 11 recall) and the channel in bit 5. Only the addressed channel changes.
- R5: If byte 0 does not match in identity or in strap bits, the remainder of the frame is ignored until cs_n goes high.
- R6: A write changes the wiper only after all 8 data bits have arrived. If cs_n rises partway through the data byte, no register changes. Otherwise a wiper changes only through a write or a recall.
- R7: A read shifts the addressed wiper out on sdo in byte 2, MSB first. sdo changes on falling sck edges, so each bit is valid before the rising edge that the master samples on.
- R8: If hold_n falls while sck is low, sck edges are ignored and the bit count and shift state are kept. When hold_n rises again while sck is low, the frame resumes exactly where it stopped.
- R9: A store copies the addressed wiper into its shadow and pulses nv_commit for one clock, with nv_commit_ch naming the channel. With wp_n low a store is dropped and no strobe occurs, but wiper writes still take effect.
- R10: A recall loads the addressed wiper from its shadow. The shadows keep their values across reset, and reset reloads the wipers from them.
- R11: For each channel c, tap_sel[c*256 + wiper_c] is the only bit set in that channel's 256-bit slice, one clock after the wiper value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Serial chip select, active low |
| sck | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in |
| hold_n | input | 1 | Pause request, active low |
| wp_n | input | 1 | Store protect, active low |
| strap | input | 2 | Address strap pins |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for sdo (low means high impedance) |
| wiper_val | output | 16 | Wiper registers, channel c in bits c*8+7:c*8 |
| tap_sel | output | 512 | One-hot tap selects, channel c in bits c*256+255:c*256 |
| nv_commit | output | 1 | Single-cycle shadow commit strobe |
| nv_commit_ch | output | 1 | Channel of the commit |

## Verification
If the bit counter or shift state is wrong, the wrong wiper value reaches wiper_val and tap_sel. This shows a few clocks after cs_n rises at the end of that frame, or as a wrong bit on sdo within the same read byte. A bad lock, pause or address-match flag shows up as a frame that should have been refused changing a wiper, or as a valid frame that leaves the wiper unchanged. A lost shadow value or a leaked protect state shows after the next recall or reset, or as a missing or extra nv_commit pulse.

// File: rtl/potctl_pkg.sv
package potctl_pkg;
  typedef enum logic [1:0] {
    OP_READ   = 2'b00,
    OP_WRITE  = 2'b01,
    OP_STORE  = 2'b10,
    OP_RECALL = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    ST_ADDR,
    ST_CMD,
    ST_DATA,
    ST_SKIP
  } frame_st_e;
endpackage

// File: rtl/potctl_sync.sv
module potctl_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/potctl_frame.sv
module potctl_frame
  import potctl_pkg::*;
#(
  parameter int W = 8,
  parameter int CHANNELS = 2,
  parameter logic [3:0] DEV_ID = 4'b0101
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          cs_s,
  input  logic                          sck_s,
  input  logic                          sdi_s,
  input  logic                          hold_s,
  input  logic                          wp_s,
  input  logic [1:0]                    strap,
  input  logic [CHANNELS*W-1:0]         wiper_flat,
  output logic                          wr_stb,
  output logic                          st_stb,
  output logic                          rc_stb,
  output logic [$clog2(CHANNELS)-1:0]   chan,
  output logic [W-1:0]                  wr_data,
  output logic                          sdo,
  output logic                          sdo_oe
);
  localparam int CW    = $clog2(CHANNELS);
  localparam int CNT_W = $clog2(W);

  logic          cs_q, sck_q, armed, paused;
  logic          cs_fall, sck_rise, sck_fall, live;
  frame_st_e     state;
  op_e           op_q, op_in;
  logic [CNT_W-1:0] cnt;
  logic [W-1:0]  sh, tx, byte_in, rd_word;
  logic [CW-1:0] byte_ch;

  always_comb begin
    cs_fall  = cs_q & ~cs_s;
    sck_rise = sck_s & ~sck_q;
    sck_fall = ~sck_s & sck_q;
    live     = armed & ~cs_s & ~paused;
    byte_in  = {sh[W-2:0], sdi_s};
    byte_ch  = byte_in[W-3 -: CW];
    op_in    = op_e'(byte_in[W-1 -: 2]);
    rd_word  = '0;
    for (int c = 0; c < CHANNELS; c++) begin
      if (byte_ch == CW'(c)) rd_word = wiper_flat[c*W +: W];
    end
  end

  // Edge history, lock and pause tracking
  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q   <= 1'b0;
      sck_q  <= 1'b0;
      armed  <= 1'b0;
      paused <= 1'b0;
    end else begin
      cs_q  <= cs_s;
      sck_q <= sck_s;
      if (cs_fall) armed <= 1'b1;
      if (cs_s) paused <= 1'b0;
      else if (!sck_s) paused <= ~hold_s;
    end
  end

  // Frame sequencer
  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_ADDR;
      op_q    <= OP_READ;
      cnt     <= '0;
      sh      <= '0;
      tx      <= '0;
      sdo     <= 1'b0;
      sdo_oe  <= 1'b0;
      wr_stb  <= 1'b0;
      st_stb  <= 1'b0;
      rc_stb  <= 1'b0;
      chan    <= '0;
      wr_data <= '0;
    end else begin
      wr_stb <= 1'b0;
      st_stb <= 1'b0;
      rc_stb <= 1'b0;
      sdo_oe <= armed & ~cs_s;
      if (cs_s) begin
        state <= ST_ADDR;
        cnt   <= '0;
        sdo   <= 1'b0;
      end else if (live) begin
        if (sck_rise) begin
          sh <= byte_in;
          if (cnt == CNT_W'(W-1)) begin
            cnt <= '0;
            case (state)
              ST_ADDR: begin
                if (byte_in[W-1 -: 4] == DEV_ID && byte_in[W-5 -: 2] == strap)
                  state <= ST_CMD;
                else
                  state <= ST_SKIP;
              end
              ST_CMD: begin
                op_q <= op_in;
                chan <= byte_ch;
                case (op_in)
                  OP_READ: begin
                    tx    <= rd_word;
                    state <= ST_DATA;
                  end
                  OP_WRITE: state <= ST_DATA;
                  OP_STORE: begin
                    st_stb <= wp_s;
                    state  <= ST_SKIP;
                  end
                  default: begin
                    rc_stb <= 1'b1;
                    state  <= ST_SKIP;
                  end
                endcase
              end
              ST_DATA: begin
                if (op_q == OP_WRITE) begin
                  wr_stb  <= 1'b1;
                  wr_data <= byte_in;
                end
                state <= ST_SKIP;
              end
              default: state <= ST_SKIP;
            endcase
          end else begin
            cnt <= cnt + 1'b1;
          end
        end else if (sck_fall && state == ST_DATA && op_q == OP_READ) begin
          sdo <= tx[W-1];
          tx  <= {tx[W-2:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/potctl_wipers.sv
module potctl_wipers #(
  parameter int W = 8,
  parameter int CHANNELS = 2,
  parameter logic [W-1:0] NV_INIT = 8'h80
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_stb,
  input  logic                        st_stb,
  input  logic                        rc_stb,
  input  logic [$clog2(CHANNELS)-1:0] chan,
  input  logic [W-1:0]                wr_data,
  output logic [CHANNELS*W-1:0]       wiper_flat,
  output logic                        nv_commit,
  output logic [$clog2(CHANNELS)-1:0] nv_commit_ch
);
  localparam int CW = $clog2(CHANNELS);

  logic [W-1:0] nv_mem [CHANNELS] = '{default: NV_INIT};
  logic [W-1:0] store_word;

  always_comb begin
    store_word = '0;
    for (int c = 0; c < CHANNELS; c++) begin
      if (chan == CW'(c)) store_word = wiper_flat[c*W +: W];
    end
  end

  // Shadow storage, single write port, not cleared by reset
  always_ff @(posedge clk) begin
    if (st_stb) nv_mem[chan] <= store_word;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      nv_commit    <= 1'b0;
      nv_commit_ch <= '0;
    end else begin
      nv_commit    <= st_stb;
      nv_commit_ch <= st_stb ? chan : nv_commit_ch;
    end
  end

  for (genvar c = 0; c < CHANNELS; c++) begin : g_chan
    logic [W-1:0] w_q;
    always_ff @(posedge clk) begin
      if (rst) w_q <= nv_mem[c];
      else if (wr_stb && chan == CW'(c)) w_q <= wr_data;
      else if (rc_stb && chan == CW'(c)) w_q <= nv_mem[c];
    end
    assign wiper_flat[c*W +: W] = w_q;
  end
endmodule

// File: rtl/potctl_tapdec.sv
module potctl_tapdec #(
  parameter int W = 8,
  localparam int TAPS = 1 << W
) (
  input  logic            clk,
  input  logic [W-1:0]    wiper,
  output logic [TAPS-1:0] tap
);
  always_ff @(posedge clk) begin
    for (int t = 0; t < TAPS; t++) begin
      tap[t] <= (wiper == W'(t));
    end
  end
endmodule

// File: rtl/potctl_spi_wiper.sv
module potctl_spi_wiper #(
  parameter int W = 8,
  parameter int CHANNELS = 2,
  parameter logic [3:0] DEV_ID = 4'b0101,
  parameter logic [W-1:0] NV_INIT = 8'h80
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            cs_n,
  input  logic                            sck,
  input  logic                            sdi,
  input  logic                            hold_n,
  input  logic                            wp_n,
  input  logic [1:0]                      strap,
  output logic                            sdo,
  output logic                            sdo_oe,
  output logic [CHANNELS*W-1:0]           wiper_val,
  output logic [CHANNELS*(1<<W)-1:0]      tap_sel,
  output logic                            nv_commit,
  output logic [$clog2(CHANNELS)-1:0]     nv_commit_ch
);
  localparam int TAPS = 1 << W;
  localparam int CW   = $clog2(CHANNELS);

  logic cs_s, sck_s, sdi_s, hold_s, wp_s;
  logic wr_stb, st_stb, rc_stb;
  logic [CW-1:0] chan;
  logic [W-1:0]  wr_data;

  potctl_sync #(.W(5), .RST_VAL(5'b00011)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({cs_n, sck, sdi, hold_n, wp_n}),
    .q   ({cs_s, sck_s, sdi_s, hold_s, wp_s})
  );

  potctl_frame #(.W(W), .CHANNELS(CHANNELS), .DEV_ID(DEV_ID)) u_frame (
    .clk        (clk),
    .rst        (rst),
    .cs_s       (cs_s),
    .sck_s      (sck_s),
    .sdi_s      (sdi_s),
    .hold_s     (hold_s),
    .wp_s       (wp_s),
    .strap      (strap),
    .wiper_flat (wiper_val),
    .wr_stb     (wr_stb),
    .st_stb     (st_stb),
    .rc_stb     (rc_stb),
    .chan       (chan),
    .wr_data    (wr_data),
    .sdo        (sdo),
    .sdo_oe     (sdo_oe)
  );

  potctl_wipers #(.W(W), .CHANNELS(CHANNELS), .NV_INIT(NV_INIT)) u_wipers (
    .clk          (clk),
    .rst          (rst),
    .wr_stb       (wr_stb),
    .st_stb       (st_stb),
    .rc_stb       (rc_stb),
    .chan         (chan),
    .wr_data      (wr_data),
    .wiper_flat   (wiper_val),
    .nv_commit    (nv_commit),
    .nv_commit_ch (nv_commit_ch)
  );

  for (genvar c = 0; c < CHANNELS; c++) begin : g_dec
    potctl_tapdec #(.W(W)) u_dec (
      .clk   (clk),
      .wiper (wiper_val[c*W +: W]),
      .tap   (tap_sel[c*TAPS +: TAPS])
    );
  end
endmodule

// File: rtl/potctl_spi_wiper_chk.sv
module potctl_spi_wiper_chk #(
  parameter int W = 8,
  parameter int CHANNELS = 2,
  localparam int TAPS = 1 << W
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     cs_s,
  input logic                     wp_s,
  input logic                     sdo_oe,
  input logic                     wr_stb,
  input logic                     rc_stb,
  input logic                     st_stb,
  input logic                     nv_commit,
  input logic [CHANNELS*W-1:0]    wiper_val,
  input logic [CHANNELS*TAPS-1:0] tap_sel
);
  for (genvar c = 0; c < CHANNELS; c++) begin : g_tap
    // R11
    tap_onehot_chk: assert property (@(posedge clk) disable iff (rst)
      $countones(tap_sel[c*TAPS +: TAPS]) == 1);
    // R11
    tap_index_chk: assert property (@(posedge clk) disable iff (rst)
      tap_sel[c*TAPS +: TAPS] == (TAPS'(1) << $past(wiper_val[c*W +: W])));
  end

  // R2
  deselect_oe_chk: assert property (@(posedge clk) disable iff (rst)
    cs_s |=> !sdo_oe);

  // R9
  store_protect_chk: assert property (@(posedge clk) disable iff (rst)
    st_stb |-> $past(wp_s));

  // R9
  commit_follow_chk: assert property (@(posedge clk) disable iff (rst)
    st_stb |=> nv_commit);

  // R6
  wiper_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_stb || rc_stb) |=> $stable(wiper_val));
endmodule

bind potctl_spi_wiper potctl_spi_wiper_chk #(.W(W), .CHANNELS(CHANNELS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cs_s      (cs_s),
  .wp_s      (wp_s),
  .sdo_oe    (sdo_oe),
  .wr_stb    (wr_stb),
  .rc_stb    (rc_stb),
  .st_stb    (st_stb),
  .nv_commit (nv_commit),
  .wiper_val (wiper_val),
  .tap_sel   (tap_sel)
);

// File: tb/potctl_spi_wiper_bench.sv
`timescale 1ns/1ps
module potctl_spi_wiper_bench;
  localparam int HP = 6;
  localparam logic [7:0] ADDR = 8'h58;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b0, sck = 1'b0, sdi = 1'b0, hold_n = 1'b1, wp_n = 1'b1;
  logic [1:0] strap = 2'b10;
  logic sdo, sdo_oe, nv_commit;
  logic [15:0] wiper_val;
  logic [511:0] tap_sel;
  logic [0:0] nv_commit_ch;

  int checks = 0, failures = 0, commits = 0, last_ch = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  potctl_spi_wiper u_potctl_spi_wiper (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .sdi(sdi), .hold_n(hold_n),
    .wp_n(wp_n), .strap(strap), .sdo(sdo), .sdo_oe(sdo_oe), .wiper_val(wiper_val),
    .tap_sel(tap_sel), .nv_commit(nv_commit), .nv_commit_ch(nv_commit_ch)
  );

  always @(posedge clk) begin
    if (!rst && nv_commit) begin
      commits <= commits + 1;
      last_ch <= int'(nv_commit_ch);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int wip(input int c);
    return int'(wiper_val[c*8 +: 8]);
  endfunction

  function automatic bit tap_ok(input int c, input int v);
    return tap_sel[c*256 + v] && ($countones(tap_sel[c*256 +: 256]) == 1);
  endfunction

  task automatic do_pause();
    hold_n = 1'b0;
    tick(HP);
    repeat (3) begin
      sdi = ~sdi; sck = 1'b1; tick(HP);
      sck = 1'b0; tick(HP);
    end
    hold_n = 1'b1;
    tick(HP);
  endtask

  task automatic spi_bits(input logic [7:0] tx, input int nbits, input int pause_at,
                          output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i >= 8 - nbits; i--) begin
      if (7 - i == pause_at) do_pause();
      sdi = tx[i];
      tick(HP);
      rx[i] = sdo;
      sck = 1'b1;
      tick(HP);
      sck = 1'b0;
    end
  endtask

  task automatic frame(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2,
                       input int nbits2, input int pause_at,
                       output logic [7:0] rx, output bit oe_seen);
    logic [7:0] junk;
    cs_n = 1'b0;
    tick(HP);
    spi_bits(b0, 8, 8, junk);
    spi_bits(b1, 8, 8, junk);
    rx = '0;
    if (nbits2 > 0) spi_bits(b2, nbits2, pause_at, rx);
    tick(HP);
    oe_seen = sdo_oe;
    cs_n = 1'b1;
    tick(10);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    tick(10);
    rst = 1'b0;
    tick(4);
  endtask

  initial begin
    #950000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] rx, junk;
    bit oe;
    int v, last1;

    do_reset();
    // R1 reset state
    check(wip(0) == 8'h80, "R1 wiper0", wip(0), 8'h80);
    check(wip(1) == 8'h80, "R1 wiper1", wip(1), 8'h80);
    check(tap_ok(0, 128) && tap_ok(1, 128), "R1 taps", 0, 128);
    check(sdo_oe == 1'b0, "R1 sdo_oe", int'(sdo_oe), 0);
    check(commits == 0, "R1 no commit", commits, 0);

    // R3 locked: cs_n low since reset, frame ignored
    spi_bits(ADDR, 8, 8, junk);
    spi_bits(8'h40, 8, 8, junk);
    spi_bits(8'h11, 8, 8, junk);
    tick(HP);
    check(sdo_oe == 1'b0, "R3 locked oe", int'(sdo_oe), 0);
    cs_n = 1'b1;
    tick(10);
    check(wip(0) == 8'h80, "R3 locked write ignored", wip(0), 8'h80);

    // R4 R6 R11 exhaustive write sweep on channel 0
    for (int k = 0; k < 256; k++) begin
      frame(ADDR, 8'h40, 8'(k), 8, 8, rx, oe);
      check(wip(0) == k, "R6 write ch0", wip(0), k);
      check(tap_ok(0, k), "R11 tap ch0", wip(0), k);
      check(wip(1) == 8'h80, "R4 ch1 untouched", wip(1), 8'h80);
    end

    // R7 R2 channel 1 write then read back
    frame(ADDR, 8'h00, 8'h00, 8, 8, rx, oe);
    check(rx == 8'hFF, "R7 read ch0", int'(rx), 8'hFF);
    last1 = 0;
    for (int k = 0; k < 16; k++) begin
      v = (k * 17) ^ 8'h5A;
      frame(ADDR, 8'h60, 8'(v), 8, 8, rx, oe);
      frame(ADDR, 8'h20, 8'h00, 8, 8, rx, oe);
      check(rx == 8'(v), "R7 read ch1", int'(rx), v);
      check(oe == 1'b1, "R2 oe while selected", int'(oe), 1);
      check(tap_ok(1, v), "R11 tap ch1", wip(1), v);
      last1 = v;
    end
    check(sdo_oe == 1'b0, "R2 oe after deselect", int'(sdo_oe), 0);

    // R5 address mismatch
    frame(8'h78, 8'h40, 8'h12, 8, 8, rx, oe);
    check(wip(0) == 8'hFF, "R5 id mismatch", wip(0), 8'hFF);
    frame(8'h5C, 8'h40, 8'h12, 8, 8, rx, oe);
    check(wip(0) == 8'hFF, "R5 strap mismatch", wip(0), 8'hFF);

    // R6 partial data byte discarded
    frame(ADDR, 8'h40, 8'h00, 5, 8, rx, oe);
    check(wip(0) == 8'hFF, "R6 partial byte", wip(0), 8'hFF);
    frame(ADDR, 8'h40, 8'h21, 8, 8, rx, oe);
    check(wip(0) == 8'h21, "R2 next frame clean", wip(0), 8'h21);

    // R8 hold pause
    frame(ADDR, 8'h40, 8'hA5, 8, 3, rx, oe);
    check(wip(0) == 8'hA5, "R8 pause write", wip(0), 8'hA5);
    frame(ADDR, 8'h40, 8'h3C, 8, 0, rx, oe);
    check(wip(0) == 8'h3C, "R8 pause at start", wip(0), 8'h3C);
    frame(ADDR, 8'h20, 8'h00, 8, 5, rx, oe);
    check(rx == 8'(last1), "R8 pause read", int'(rx), last1);

    // R9 protect blocks store, not volatile write
    wp_n = 1'b0;
    tick(6);
    frame(ADDR, 8'hA0, 8'h00, 0, 8, rx, oe);
    check(commits == 0, "R9 store blocked", commits, 0);
    frame(ADDR, 8'h60, 8'h77, 8, 8, rx, oe);
    check(wip(1) == 8'h77, "R9 write under protect", wip(1), 8'h77);
    wp_n = 1'b1;
    tick(6);
    frame(ADDR, 8'h60, 8'h33, 8, 8, rx, oe);
    frame(ADDR, 8'hA0, 8'h00, 0, 8, rx, oe);
    check(commits == 1, "R9 store strobe", commits, 1);
    check(last_ch == 1, "R9 store channel", last_ch, 1);

    // R10 recall and persistence over reset
    frame(ADDR, 8'h60, 8'h44, 8, 8, rx, oe);
    frame(ADDR, 8'hE0, 8'h00, 0, 8, rx, oe);
    check(wip(1) == 8'h33, "R10 recall ch1", wip(1), 8'h33);
    check(wip(0) == 8'h3C, "R10 recall other ch", wip(0), 8'h3C);
    frame(ADDR, 8'h60, 8'h55, 8, 8, rx, oe);
    cs_n = 1'b1;
    do_reset();
    check(wip(1) == 8'h33, "R10 reset reload ch1", wip(1), 8'h33);
    check(wip(0) == 8'h80, "R10 reset reload ch0", wip(0), 8'h80);
    check(tap_ok(1, 8'h33), "R11 tap after reset", wip(1), 8'h33);

    // R3 first falling edge unlocks
    frame(ADDR, 8'h40, 8'h01, 8, 8, rx, oe);
    check(wip(0) == 8'h01, "R3 unlocked by cs fall", wip(0), 1);
    check(commits == 1, "R9 no extra strobe", commits, 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule